// File: doc/BRIEF.md
# Media-independent interface start-of-frame detector

This block sits on the 4-bit nibble bus of a media-independent interface, on either the transmit or the receive side, and watches it together with the qualifier that marks valid nibbles. That qualifier is the transmit enable on the transmit side and data-valid on the receive side. A frame opens with a run of alternating-pattern nibbles (value 0x5) and is closed off by a delimiter nibble of 0xD. The first data nibble comes right after the delimiter. The detector checks the whole nibble sequence under the qualifier, not a single bus wire. It raises a one-cycle start pulse on the first data nibble.

A configurable minimum run of 0x5 nibbles must come before the 0xD. This lets a preamble that is shorter than nominal still give a detection. A malformed preamble raises an error flag, and the rest of that frame is then ignored. A falling qualifier returns the detector to idle from any state. Downstream logic uses the start pulse and the in-frame flag to begin frame capture. It uses the error flag to drop the frame.

Top module: `mii_sof_detect`

## Requirements
- R1: While rst_ni is low, sof_o, in_frame_o and pre_err_o are 0, regardless of nib_i and qual_i.
- R2: sof_o is 1 for exactly one cycle per accepted frame. That cycle is the one right after the cycle carrying the 0xD delimiter, and only if qual_i is still 1 in it. sof_o is never 1 in any other cycle.
- R3: A frame with the nominal preamble (fifteen 0x5 nibbles, then 0xD) is accepted. The first nibble is presented together with the rising qual_i.
- R4: A frame whose 0xD follows exactly MIN_RUN consecutive 0x5 nibbles, counted from the start of the frame, is accepted.
- R5: A 0xD that arrives after fewer than MIN_RUN 0x5 nibbles, including a 0xD as the very first nibble, sets pre_err_o in the next cycle. In that case sof_o stays 0.
- R6: Any nibble other than 0x5 or 0xD that arrives before the delimiter sets pre_err_o in the next cycle. In that case sof_o stays 0.
- R7: Once pre_err_o is set, it stays 1 and sof_o and in_frame_o stay 0 for as long as qual_i stays 1, even if a valid preamble and delimiter follow.
- R8: in_frame_o is 1 in every cycle where qual_i is 1 and the bus carries a data nibble of an accepted frame. In all other cycles it is 0.
- R9: The first cycle with qual_i low returns the detector to idle from any state. pre_err_o is 0 from the next cycle on. A preamble cut short by qual_i falling raises no error. A frame whose qual_i rises right after that low cycle is detected normally.
- R10: A preamble with more than fifteen 0x5 nibbles is accepted. The run count saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock, one nibble per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nib_i | input | NIB_W | Nibble bus, bit 0 first on the wire |
| qual_i | input | 1 | Transmit enable or receive data-valid |
| sof_o | output | 1 | One-cycle pulse on the first data nibble |
| in_frame_o | output | 1 | High on data nibbles of an accepted frame |
| pre_err_o | output | 1 | Preamble error, held until qual_i falls |

## Verification
The bench builds the detector with MIN_RUN set to 3 instead of the default 2. With that value, runs of two and three 0x5 nibbles sit on either side of the acceptance threshold, so both outcomes are tested against one limit. The nominal run of fifteen and a run of twenty check that the saturating count accepts long preambles. The stimulus also covers the qualifier falling in every state, including right after the delimiter, where the start pulse must not appear.

// File: rtl/sofd_pkg.sv
package sofd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } sofd_state_e;
endpackage

// File: rtl/sofd_classify.sv
module sofd_classify #(
  parameter int          NIB_W   = 4,
  parameter logic [3:0]  PRE_VAL = 4'h5,
  parameter logic [3:0]  DLM_VAL = 4'hD
) (
  input  logic [NIB_W-1:0] nib_i,
  output logic             is_pre_o,
  output logic             is_dlm_o
);
  localparam logic [NIB_W-1:0] PRE_C = NIB_W'(PRE_VAL);
  localparam logic [NIB_W-1:0] DLM_C = NIB_W'(DLM_VAL);

  logic [NIB_W-1:0] pre_hit, dlm_hit;

  // per-bit match so every wire of the bus takes part
  for (genvar b = 0; b < NIB_W; b++) begin : g_bit
    assign pre_hit[b] = (nib_i[b] == PRE_C[b]);
    assign dlm_hit[b] = (nib_i[b] == DLM_C[b]);
  end

  assign is_pre_o = &pre_hit;
  assign is_dlm_o = &dlm_hit;
endmodule

// File: rtl/sofd_run_cnt.sv
module sofd_run_cnt #(
  parameter int MIN_RUN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic reached_o
);
  localparam int              CNT_W = $clog2(MIN_RUN + 1);
  localparam logic [CNT_W-1:0] LIM  = CNT_W'(MIN_RUN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q == LIM);
endmodule

// File: rtl/sofd_fsm.sv
module sofd_fsm
  import sofd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        qual_i,
  input  logic        is_pre_i,
  input  logic        is_dlm_i,
  input  logic        run_ok_i,
  output sofd_state_e state_o,
  output logic        sof_pend_o
);
  sofd_state_e state_q, state_d;
  logic        pend_d;

  always_comb begin
    state_d = state_q;
    pend_d  = 1'b0;
    if (!qual_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_PRE: begin
          if (is_pre_i)                  state_d = ST_PRE;
          else if (is_dlm_i && run_ok_i) begin
            state_d = ST_DATA;
            pend_d  = 1'b1;
          end else                       state_d = ST_SKIP;
        end
        ST_DATA: state_d = ST_DATA;
        ST_SKIP: state_d = ST_SKIP;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sof_pend_o <= 1'b0;
    end else begin
      state_q <= state_d;
      sof_pend_o <= pend_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/mii_sof_detect.sv
module mii_sof_detect
  import sofd_pkg::*;
#(
  parameter int         NIB_W   = 4,
  parameter int         MIN_RUN = 2,
  parameter logic [3:0] PRE_VAL = 4'h5,
  parameter logic [3:0] DLM_VAL = 4'hD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             qual_i,
  output logic             sof_o,
  output logic             in_frame_o,
  output logic             pre_err_o
);
  logic        is_pre, is_dlm, run_ok, sof_pend;
  sofd_state_e state;

  sofd_classify #(.NIB_W(NIB_W), .PRE_VAL(PRE_VAL), .DLM_VAL(DLM_VAL)) i_classify (
    .nib_i    (nib_i),
    .is_pre_o (is_pre),
    .is_dlm_o (is_dlm)
  );

  // count 0x5 nibbles only while looking for the delimiter
  sofd_run_cnt #(.MIN_RUN(MIN_RUN)) i_run_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!qual_i || !(state == ST_IDLE || state == ST_PRE)),
    .inc_i     (is_pre),
    .reached_o (run_ok)
  );

  sofd_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .qual_i     (qual_i),
    .is_pre_i   (is_pre),
    .is_dlm_i   (is_dlm),
    .run_ok_i   (run_ok),
    .state_o    (state),
    .sof_pend_o (sof_pend)
  );

  // gate with the qualifier: no pulse or flag on a nibble that is not valid
  assign sof_o      = sof_pend && qual_i;
  assign in_frame_o = (state == ST_DATA) && qual_i;
  assign pre_err_o  = (state == ST_SKIP);
endmodule

// File: rtl/mii_sof_detect_chk.sv
module mii_sof_detect_chk #(
  parameter int         NIB_W   = 4,
  parameter logic [3:0] DLM_VAL = 4'hD
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NIB_W-1:0] nib_i,
  input logic             qual_i,
  input logic             sof_o,
  input logic             in_frame_o,
  input logic             pre_err_o
);
  assert_sof_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  assert_sof_after_dlm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> ($past(nib_i) == NIB_W'(DLM_VAL)) && $past(qual_i));

  assert_sof_in_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> in_frame_o);

  assert_no_frame_unqual_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual_i |-> !in_frame_o && !sof_o);

  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_err_o && qual_i) |=> pre_err_o);

  assert_err_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_err_o |-> !in_frame_o && !sof_o);

  assert_drop_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual_i |=> !pre_err_o);

  always_comb begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!sof_o && !in_frame_o && !pre_err_o);
  end
endmodule

bind mii_sof_detect mii_sof_detect_chk #(.NIB_W(NIB_W), .DLM_VAL(DLM_VAL)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .nib_i      (nib_i),
  .qual_i     (qual_i),
  .sof_o      (sof_o),
  .in_frame_o (in_frame_o),
  .pre_err_o  (pre_err_o)
);

// File: tb/test_mii_sof_detect.sv
`timescale 1ns/1ps
module test_mii_sof_detect;
  localparam int MINR = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic       qual_i = 1'b0;
  logic       sof_o, in_frame_o, pre_err_o;

  int n_run = 0, n_fail = 0, sof_seen = 0;
  // reference model: 0 idle, 1 preamble, 2 data, 3 skip
  int m_mode = 0, m_run = 0;
  bit m_pend = 0;

  mii_sof_detect #(.MIN_RUN(MINR)) i_mii_sof_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .nib_i(nib_i), .qual_i(qual_i),
    .sof_o(sof_o), .in_frame_o(in_frame_o), .pre_err_o(pre_err_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // drive one nibble, compare all outputs before the edge, then advance the model
  task automatic step(string tag, logic [3:0] n, logic q);
    @(negedge clk_i);
    nib_i = n; qual_i = q;
    #4;
    chk(tag, "sof", sof_o, m_pend && q);
    chk(tag, "in_frame", in_frame_o, (m_mode == 2) && q);
    chk(tag, "pre_err", pre_err_o, m_mode == 3);
    if (sof_o) sof_seen++;
    @(posedge clk_i);
    m_pend = 0;
    if (!q) begin
      m_mode = 0; m_run = 0;
    end else if (m_mode <= 1) begin
      if (n == 4'h5) begin m_mode = 1; m_run++; end
      else if (n == 4'hD && m_run >= MINR) begin m_mode = 2; m_pend = 1; end
      else m_mode = 3;
    end
  endtask

  task automatic frame(string tag, int pre, logic [3:0] dl, int data, int gap);
    for (int i = 0; i < pre; i++) step(tag, 4'h5, 1'b1);
    step(tag, dl, 1'b1);
    for (int i = 0; i < data; i++) step(tag, 4'(i * 3 + 1), 1'b1);
    for (int i = 0; i < gap; i++) step(tag, 4'h0, 1'b0);
  endtask

  task automatic expect_sofs(string tag, int exp);
    n_run++;
    if (sof_seen != exp) begin
      n_fail++;
      $display("FAIL %s sof_count actual=%0d expected=%0d", tag, sof_seen, exp);
    end
    sof_seen = 0;
  endtask

  initial begin
    // R1: reset with active-looking inputs
    nib_i = 4'h5; qual_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); #4;
      chk("R1", "sof", sof_o, 1'b0);
      chk("R1", "in_frame", in_frame_o, 1'b0);
      chk("R1", "pre_err", pre_err_o, 1'b0);
    end
    @(negedge clk_i); qual_i = 1'b0; rst_ni = 1'b1;
    step("R1", 4'h0, 1'b0);

    frame("R3", 15, 4'hD, 6, 2);        expect_sofs("R3", 1);
    frame("R4", MINR, 4'hD, 4, 1);      expect_sofs("R4", 1);
    frame("R5", MINR - 1, 4'hD, 3, 1);  expect_sofs("R5", 0);
    frame("R5", 0, 4'hD, 2, 1);         expect_sofs("R5", 0);
    // R6 bad nibble, then R7 valid preamble inside the same frame
    step("R6", 4'h5, 1'b1); step("R6", 4'h5, 1'b1); step("R6", 4'h7, 1'b1);
    frame("R7", 8, 4'hD, 4, 1);         expect_sofs("R7", 0);
    // R9 truncated preamble, then immediate long frame
    frame("R9", 3, 4'h5, 0, 1);
    frame("R10", 20, 4'hD, 3, 0);
    step("R9", 4'h0, 1'b0);
    frame("R9", 4, 4'hD, 2, 1);         expect_sofs("R9", 2);
    // R2 qualifier drops right after delimiter
    frame("R2", 5, 4'hD, 0, 2);         expect_sofs("R2", 0);
    // R8 long data stretch
    frame("R8", 7, 4'hD, 12, 3);        expect_sofs("R8", 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule